// File: doc/BRIEF.md
# QSPI Generic Command Length Decoder

This block sits between the generic command queue of a quad-capable SPI controller and its byte-wide shift engine. When the queue offers a command word and the block is idle, the block takes the word, works out how many bytes the entry moves on the bus, and loads that number into a down-counter. The shift engine returns one pulse per byte it has finished. Each pulse lowers the counter by one, and the block stays busy until the last byte is done.

A command word is read in one of three ways. It can give a plain byte count. It can give a power-of-two length, for long transfers. It can give a number of idle (dummy) clock cycles, which the block turns into the smallest whole number of bytes that covers them at the lane width of the chosen bus mode. Words that give a length the block cannot produce set an error flag. Words that come to zero bytes finish at once.

Top module: `qspi_len_decoder`

## Requirements
- R1: `cmd_ready` is high exactly when `busy` is low. A word is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and the decoded result shows on the outputs from the next cycle. Word layout: bits [7:0] immediate, bit 8 transfer flag, bit 9 power-of-two flag, bits [11:10] bus mode, bit 16 transmit flag, bit 17 receive flag. All other bits are ignored.
- R2: If the transfer flag is 1, the power-of-two flag is 0, and at least one of transmit or receive is 1, the count loaded is the immediate value.
- R3: If the transfer flag and the power-of-two flag are both 1 and the immediate is 8 or less, the count loaded is 2 to the power of the immediate. This happens whatever the transmit and receive flags are.
- R4: A power-of-two word with an immediate above 8 loads 256, sets `err` and sets `busy`.
- R5: A word with transfer=1, power-of-two=0, transmit=0 and receive=0 is a dummy word. The count loaded is ceil(immediate × lanes / 8), with 1, 2 and 4 lanes for mode codes 1, 2 and 3. `dummy` is high while that count is non-zero and being worked off.
- R6: A dummy word with mode code 0 sets `err`, loads a count of 0 and leaves `busy` low.
- R7: A word whose count comes to zero leaves `busy` and `dummy` low and `cmd_ready` high in the cycle after it is taken. This covers an immediate of 0, a dummy word of 0 cycles, and any word with the transfer flag 0.
- R8: While busy, each cycle with `byte_done` high lowers `byte_count` by one. The pulse that takes the count from 1 to 0 clears `busy` and `dummy` in the next cycle.
- R9: `byte_done` while idle has no effect. `cmd_valid` while busy takes no word, and the count is left as it was.
- R10: After reset, `byte_count` is 0, `busy`, `dummy` and `err` are low, and `cmd_ready` is high.
- R11: `err` describes the most recent word taken. A word that decodes cleanly clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command word is offered |
| cmd_word | input | 18 | Command word from the queue |
| cmd_ready | output | 1 | Block is idle and will take a word |
| byte_done | input | 1 | Shift engine finished one byte |
| byte_count | output | 9 | Bytes still to move for the current word |
| busy | output | 1 | Count is non-zero and being worked off |
| dummy | output | 1 | Current bytes are dummy filler |
| err | output | 1 | Last word taken could not be decoded as given |

## Verification
The hardest case to reach is the largest length: a power-of-two word at the top of its range. Its count only runs down after 256 done pulses, and the saturated case must also raise the error flag. The stimulus holds `byte_done` high for the full count to walk these entries back to idle, and then follows them with a clean word to show that the error clears. A second hard case is a new word or a stray done pulse that arrives at the wrong time. The bench offers a word while the block is busy and pulses done while it is idle, then checks at the ports that the count and busy flag did not change.

// File: rtl/qlen_pkg.sv
package qlen_pkg;

  // Command word layout: bit positions that the decoder depends on
  localparam int CMD_W     = 18;
  localparam int IMM_W     = 8;
  localparam int IMM_LSB   = 0;
  localparam int XFER_BIT  = 8;
  localparam int POW_BIT   = 9;
  localparam int MODE_LSB  = 10;
  localparam int MODE_W    = 2;
  localparam int TX_BIT    = 16;
  localparam int RX_BIT    = 17;

  // Bus lane width selection
  typedef enum logic [MODE_W-1:0] {
    LANE_BAD = 2'd0,
    LANE_X1  = 2'd1,
    LANE_X2  = 2'd2,
    LANE_X4  = 2'd3
  } lane_mode_e;

  // How an entry's immediate is interpreted
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_PLAIN = 2'd1,
    KIND_POW   = 2'd2,
    KIND_DUMMY = 2'd3
  } entry_kind_e;

  typedef struct packed {
    logic [IMM_W-1:0] imm;
    logic             xfer;
    logic             pow;
    lane_mode_e       mode;
    logic             tx;
    logic             rx;
  } cmd_fields_t;

endpackage

// File: rtl/qlen_field_split.sv
module qlen_field_split
  import qlen_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output cmd_fields_t      fields,
  output entry_kind_e      kind
);

  logic unused_rsvd;

  always_comb begin
    fields.imm  = word[IMM_LSB +: IMM_W];
    fields.xfer = word[XFER_BIT];
    fields.pow  = word[POW_BIT];
    fields.mode = lane_mode_e'(word[MODE_LSB +: MODE_W]);
    fields.tx   = word[TX_BIT];
    fields.rx   = word[RX_BIT];
  end

  // Reserved bits carry no meaning
  assign unused_rsvd = ^{word[CMD_W-1:RX_BIT+1], word[TX_BIT-1:MODE_LSB+MODE_W]};

  // Classification; the power-of-two flag outranks the direction flags
  always_comb begin
    if (!fields.xfer)
      kind = KIND_NONE;
    else if (fields.pow)
      kind = KIND_POW;
    else if (fields.tx || fields.rx)
      kind = KIND_PLAIN;
    else
      kind = KIND_DUMMY;
  end

endmodule

// File: rtl/qlen_dummy_conv.sv
module qlen_dummy_conv
  import qlen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic [IMM_W-1:0] cycles,
  input  lane_mode_e       mode,
  output logic [CNT_W-1:0] bytes,
  output logic             bad_mode
);

  localparam int LANE_OPTS = 3;               // 1, 2, 4 lanes
  localparam int PROD_W    = IMM_W + LANE_OPTS; // room for cycles*4 + 7
  localparam int BYTE_SH   = 3;

  logic [PROD_W-1:0] bytes_by_lane [LANE_OPTS];

  // One rounding path per lane width: ceil(cycles * 2^g / 8)
  for (genvar g = 0; g < LANE_OPTS; g++) begin : g_lane
    logic [PROD_W-1:0] bit_total;
    assign bit_total        = PROD_W'(cycles) << g;
    assign bytes_by_lane[g] = (bit_total + PROD_W'(7)) >> BYTE_SH;
  end

  always_comb begin
    bad_mode = 1'b0;
    bytes    = '0;
    unique case (mode)
      LANE_X1: bytes = CNT_W'(bytes_by_lane[0]);
      LANE_X2: bytes = CNT_W'(bytes_by_lane[1]);
      LANE_X4: bytes = CNT_W'(bytes_by_lane[2]);
      default: bad_mode = 1'b1;
    endcase
  end

endmodule

// File: rtl/qlen_len_calc.sv
module qlen_len_calc
  import qlen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  cmd_fields_t      fields,
  input  entry_kind_e      kind,
  input  logic [CNT_W-1:0] dummy_bytes,
  input  logic             dummy_bad,
  output logic [CNT_W-1:0] load_cnt,
  output logic             load_err,
  output logic             load_dummy
);

  localparam int MAX_EXP = CNT_W - 1;
  localparam int SH_W    = $clog2(CNT_W);

  logic [CNT_W-1:0] pow_cnt;
  logic             pow_over;

  always_comb begin
    pow_over = (fields.imm > IMM_W'(MAX_EXP));
    if (pow_over)
      pow_cnt = CNT_W'(1) << MAX_EXP;
    else
      pow_cnt = CNT_W'(1) << fields.imm[SH_W-1:0];
  end

  always_comb begin
    load_cnt   = '0;
    load_err   = 1'b0;
    load_dummy = 1'b0;
    unique case (kind)
      KIND_PLAIN: load_cnt = CNT_W'(fields.imm);
      KIND_POW: begin
        load_cnt = pow_cnt;
        load_err = pow_over;
      end
      KIND_DUMMY: begin
        load_cnt   = dummy_bad ? '0 : dummy_bytes;
        load_err   = dummy_bad;
        load_dummy = !dummy_bad;
      end
      default: load_cnt = '0;
    endcase
  end

endmodule

// File: rtl/qlen_counter.sv
module qlen_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             load_err,
  input  logic             load_dummy,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             busy_q,
  output logic             dummy_q,
  output logic             err_q
);

  logic [CNT_W-1:0] cnt_d;
  logic             busy_d;
  logic             dummy_d;
  logic             err_d;
  logic             load_nz;
  logic             take_step;
  logic             en;

  assign load_nz   = (load_cnt != '0);
  assign take_step = busy_q && step;
  assign en        = accept || take_step;

  always_comb begin
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    dummy_d = dummy_q;
    err_d   = err_q;
    if (accept) begin
      cnt_d   = load_cnt;
      busy_d  = load_nz;
      dummy_d = load_dummy && load_nz;
      err_d   = load_err;
    end else if (take_step) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_d  = 1'b0;
        dummy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      dummy_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (en) begin
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      dummy_q <= dummy_d;
      err_q   <= err_d;
    end
  end

endmodule

// File: rtl/qspi_len_decoder.sv
module qspi_len_decoder
  import qlen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             cmd_ready,
  input  logic             byte_done,
  output logic [CNT_W-1:0] byte_count,
  output logic             busy,
  output logic             dummy,
  output logic             err
);

  cmd_fields_t      fields;
  entry_kind_e      kind;
  logic [CNT_W-1:0] dummy_bytes;
  logic             dummy_bad;
  logic [CNT_W-1:0] load_cnt;
  logic             load_err;
  logic             load_dummy;
  logic             accept;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  qlen_field_split u_split (
    .word   (cmd_word),
    .fields (fields),
    .kind   (kind)
  );

  qlen_dummy_conv #(.CNT_W(CNT_W)) u_dconv (
    .cycles   (fields.imm),
    .mode     (fields.mode),
    .bytes    (dummy_bytes),
    .bad_mode (dummy_bad)
  );

  qlen_len_calc #(.CNT_W(CNT_W)) u_calc (
    .fields      (fields),
    .kind        (kind),
    .dummy_bytes (dummy_bytes),
    .dummy_bad   (dummy_bad),
    .load_cnt    (load_cnt),
    .load_err    (load_err),
    .load_dummy  (load_dummy)
  );

  qlen_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .load_cnt   (load_cnt),
    .load_err   (load_err),
    .load_dummy (load_dummy),
    .step       (byte_done),
    .cnt_q      (byte_count),
    .busy_q     (busy),
    .dummy_q    (dummy),
    .err_q      (err)
  );

endmodule

// File: rtl/qlen_checker.sv
module qlen_checker
  import qlen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_word,
  input logic             cmd_ready,
  input logic             byte_done,
  input logic [CNT_W-1:0] byte_count,
  input logic             busy,
  input logic             dummy,
  input logic             err
);

  localparam int MAX_EXP = CNT_W - 1;

  logic take;
  logic pow_word;
  logic dum_word;
  logic [IMM_W-1:0] imm;

  assign take     = cmd_valid && cmd_ready;
  assign imm      = cmd_word[IMM_LSB +: IMM_W];
  assign pow_word = cmd_word[XFER_BIT] && cmd_word[POW_BIT];
  assign dum_word = cmd_word[XFER_BIT] && !cmd_word[POW_BIT] &&
                    !cmd_word[TX_BIT] && !cmd_word[RX_BIT];

  p_pow_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && pow_word && (imm <= IMM_W'(MAX_EXP))
    |=> (byte_count == (CNT_W'(1) << $past(imm))) && busy);

  p_pow_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && pow_word && (imm > IMM_W'(MAX_EXP))
    |=> (byte_count == (CNT_W'(1) << MAX_EXP)) && err && busy);

  p_dummy_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dummy |-> busy);

  p_bad_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && dum_word && (cmd_word[MODE_LSB +: MODE_W] == 2'd0)
    |=> err && !busy && (byte_count == '0));

  p_busy_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (byte_count != '0));

  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && byte_done |=> byte_count == $past(byte_count) - CNT_W'(1));

  p_last_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && byte_done && (byte_count == CNT_W'(1)) |=> !busy && !dummy);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !byte_done |=> busy && $stable(byte_count) && $stable(dummy));

  p_idle_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_valid |=> !busy && $stable(byte_count) && $stable(err));

endmodule

bind qspi_len_decoder qlen_checker #(.CNT_W(CNT_W)) u_qlen_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_word   (cmd_word),
  .cmd_ready  (cmd_ready),
  .byte_done  (byte_done),
  .byte_count (byte_count),
  .busy       (busy),
  .dummy      (dummy),
  .err        (err)
);

// File: tb/qspi_len_decoder_bench.sv
module qspi_len_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 9;

  typedef struct {
    int cnt;
    bit busy;
    bit dummy;
    bit err;
    string tag;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [17:0]   cmd_word;
  logic          cmd_ready;
  logic          byte_done;
  logic [CW-1:0] byte_count;
  logic          busy;
  logic          dummy;
  logic          err;

  int   n_run;
  int   n_fail;
  bit   acc_seen;
  exp_t sb_q[$];

  qspi_len_decoder u_qspi_len_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_word),
    .cmd_ready  (cmd_ready),
    .byte_done  (byte_done),
    .byte_count (byte_count),
    .busy       (busy),
    .dummy      (dummy),
    .err        (err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [17:0] mk(int imm, bit xfer, bit pw, int mode, bit tx, bit rx);
    logic [17:0] w;
    w        = '0;
    w[7:0]   = imm[7:0];
    w[8]     = xfer;
    w[9]     = pw;
    w[11:10] = mode[1:0];
    w[16]    = tx;
    w[17]    = rx;
    return w;
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(logic [17:0] w, string tag);
    exp_t e;
    int imm;
    int lanes;
    imm     = int'(w[7:0]);
    e.cnt   = 0;
    e.err   = 0;
    e.dummy = 0;
    e.tag   = tag;
    if (w[8]) begin
      if (w[9]) begin
        if (imm > 8) begin e.cnt = 256; e.err = 1; end
        else e.cnt = 1 << imm;
      end else if (w[16] || w[17]) begin
        e.cnt = imm;
      end else begin
        case (int'(w[11:10]))
          1: lanes = 1;
          2: lanes = 2;
          3: lanes = 4;
          default: lanes = 0;
        endcase
        if (lanes == 0) e.err = 1;
        else begin
          e.cnt   = (imm * lanes + 7) / 8;
          e.dummy = (e.cnt != 0);
        end
      end
    end
    e.busy = (e.cnt != 0);
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Driver: push expectation, offer the word for one cycle
  task automatic issue(logic [17:0] w, string tag);
    sb_q.push_back(model(w, tag));
    @(negedge clk);
    cmd_word  = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  // Hold done high for n bytes, then confirm return to idle (R8)
  task automatic drain(int n);
    byte_done = 1'b1;
    repeat (n) @(negedge clk);
    byte_done = 1'b0;
    check(byte_count == 0, "R8", "count after drain", int'(byte_count), 0);
    check(!busy && !dummy && cmd_ready, "R8", "idle after drain",
          int'({busy, dummy, cmd_ready}), 1);
  endtask

  always @(posedge clk) acc_seen <= cmd_valid && cmd_ready;

  // Monitor: compare the decoded outputs the cycle after each take
  always @(negedge clk) begin
    if (rst_n && acc_seen) begin
      if (sb_q.size() == 0) begin
        check(0, "R1", "unexpected take", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(int'(byte_count) == e.cnt, e.tag, "byte_count", int'(byte_count), e.cnt);
        check(busy == e.busy && cmd_ready == !e.busy, e.tag, "busy", int'(busy), int'(e.busy));
        check(dummy == e.dummy, e.tag, "dummy", int'(dummy), int'(e.dummy));
        check(err == e.err, e.tag, "err", int'(err), int'(e.err));
      end
    end
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; byte_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check(byte_count == 0, "R10", "count", int'(byte_count), 0);
    check(!busy && !dummy && !err, "R10", "flags", int'({busy, dummy, err}), 0);
    check(cmd_ready, "R10", "ready", int'(cmd_ready), 1);

    // R2 plain counts, R8 single step
    issue(mk(5, 1, 0, 1, 1, 0), "R2");
    byte_done = 1'b1; @(negedge clk); byte_done = 1'b0;
    check(byte_count == 4, "R8", "one step", int'(byte_count), 4);
    drain(4);
    issue(mk(200, 1, 0, 3, 1, 1), "R2");
    drain(200);
    issue(mk(7, 1, 0, 0, 0, 1), "R2");
    drain(7);

    // R3 power of two
    issue(mk(3, 1, 1, 1, 1, 0), "R3");
    drain(8);
    issue(mk(0, 1, 1, 2, 0, 1), "R3");
    drain(1);
    issue(mk(8, 1, 1, 3, 0, 0), "R3");
    drain(256);

    // R4 saturation, then R11 clean word clears err
    issue(mk(9, 1, 1, 1, 1, 0), "R4");
    drain(256);
    issue(mk(2, 1, 0, 1, 1, 0), "R11");
    drain(2);

    // R5 dummy conversion
    issue(mk(8, 1, 0, 3, 0, 0), "R5");
    check(dummy, "R5", "dummy flag", int'(dummy), 1);
    drain(4);
    issue(mk(8, 1, 0, 2, 0, 0), "R5");
    drain(2);
    issue(mk(8, 1, 0, 1, 0, 0), "R5");
    drain(1);
    issue(mk(3, 1, 0, 3, 0, 0), "R5");
    drain(2);
    issue(mk(1, 1, 0, 1, 0, 0), "R5");
    drain(1);
    issue(mk(255, 1, 0, 3, 0, 0), "R5");
    drain(128);

    // R6 unknown mode, R11 clears afterwards
    issue(mk(10, 1, 0, 0, 0, 0), "R6");
    issue(mk(1, 1, 0, 1, 1, 0), "R11");
    drain(1);

    // R7 zero-length words (reserved bits set on one: R1)
    issue(mk(0, 1, 0, 1, 1, 0), "R7");
    issue(mk(40, 0, 0, 1, 1, 1) | 18'h0_F000, "R7");
    issue(mk(0, 1, 0, 3, 0, 0), "R7");
    issue(mk(6, 1, 0, 1, 1, 0) | 18'h0_F000, "R1");
    drain(6);

    // R9 done while idle is ignored
    byte_done = 1'b1; @(negedge clk); @(negedge clk); byte_done = 1'b0;
    check(byte_count == 0 && !busy, "R9", "idle done", int'(byte_count), 0);

    // R9 valid while busy is not taken
    issue(mk(5, 1, 0, 1, 1, 0), "R9");
    @(negedge clk);
    cmd_word = mk(99, 1, 0, 1, 1, 0); cmd_valid = 1'b1;
    @(negedge clk);
    check(!cmd_ready, "R1", "ready while busy", int'(cmd_ready), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(byte_count == 5 && busy, "R9", "count kept", int'(byte_count), 5);
    drain(5);

    check(sb_q.size() == 0, "R1", "pending items", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule